// File: doc/BRIEF.md
# Software Interrupt Pending/Enable Unit

This unit sits beside the control and status registers of a small 32-bit core. It holds two software interrupt sources, a user-level one and a supervisor-level one. Each source has a pending flag and an enable flag. Software raises or withdraws an interrupt only by writing the pending register through a CSR access. It permits or blocks each source by writing the enable register. No hardware event line can set a pending flag.

The unit combines every pending flag whose enable is set, gates the result with a global interrupt enable, and sends one interrupt request to the core's trap logic. A cause word goes with the request. The supervisor source wins when both sources are eligible. Taking the trap leaves the pending flag set, so the request stays up until the handler clears the flag.

Top module: `swi_unit`

## Requirements
- R1: After a synchronous reset, both pending flags and both enable flags are 0, so both registers read 0 and `irq_req` is low.
- R2: The pending register is at CSR address 0x7C4. The user flag is bit 0 and the supervisor flag is bit 1. A write with `csr_we` high loads these two bits from `csr_wdata` at the next rising clock edge, and writing 0 clears a flag.
- R3: The enable register is at CSR address 0x7C0. The user enable is bit 0 and the supervisor enable is bit 1. It is written the same way as the pending register.
- R4: `csr_rdata` shows the addressed register in the same cycle, with no clock edge between address and data. Bits 31:2 always read 0 and ignore writes. Any other address reads 0, and a write to it changes neither register.
- R5: `irq_req` is high exactly when `glb_ie` is high and at least one source has both its pending flag and its enable flag set.
- R6: While `irq_req` is high, `irq_cause` is 0x80000001 if the supervisor source is eligible and 0x80000000 otherwise. Bit 31 set keeps these codes apart from synchronous exception codes 0 to 11. While `irq_req` is low, `irq_cause` is 0.
- R7: `trap_ack` has no effect on the pending flags. A pending flag changes only through a CSR write.
- R8: With `csr_we` low, neither register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write strobe |
| csr_rdata | output | 32 | CSR read data, combinational |
| glb_ie | input | 1 | Global interrupt enable |
| trap_ack | input | 1 | Core has taken the trap |
| irq_req | output | 1 | Combined interrupt request |
| irq_cause | output | 32 | Cause word for the request |

## Verification
The stimulus walks the pending and enable registers through the four flag combinations of each source. This separates gating by each source's own enable from gating by the global enable, and it exposes a wrong priority when both sources are eligible. Write data that sets only bits 31:2, writes to an unmapped address, and cycles with the strobe low each show whether a stray write can reach the flags. Repeated `trap_ack` pulses while an interrupt is pending show whether the flag survives until software clears it.

// File: rtl/swi_pkg.sv
package swi_pkg;
    localparam int XLEN      = 32;
    localparam int AW        = 12;
    localparam int NSRC      = 2;
    localparam int SRC_USER  = 0;
    localparam int SRC_SUPV  = 1;
    localparam int CODE_W    = XLEN - 1;

    localparam logic [AW-1:0] ADDR_PEND = 12'h7C4;
    localparam logic [AW-1:0] ADDR_EN   = 12'h7C0;

    // synchronous exception codes; interrupts differ by bit 31
    typedef enum logic [3:0] {
        EXC_FETCH_MISALIGN = 4'd0,
        EXC_FETCH_FAULT    = 4'd1,
        EXC_BAD_OPCODE     = 4'd2,
        EXC_BREAK          = 4'd3,
        EXC_LOAD_FAULT     = 4'd5,
        EXC_ATOMIC_ALIGN   = 4'd6,
        EXC_STORE_FAULT    = 4'd7,
        EXC_ENV_CALL_BASE  = 4'd8
    } exc_code_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_EN   = 2'd2
    } csr_sel_e;

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] en;
    } swi_state_t;

    function automatic logic [XLEN-1:0] irq_cause_word(input int src);
        logic [XLEN-1:0] w;
        w = '0;
        w[XLEN-1] = 1'b1;
        w[CODE_W-1:0] = CODE_W'(src);
        return w;
    endfunction

    function automatic logic [XLEN-1:0] widen(input logic [NSRC-1:0] v);
        return {{(XLEN-NSRC){1'b0}}, v};
    endfunction
endpackage

// File: rtl/swi_csr_port.sv
module swi_csr_port
    import swi_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  swi_state_t      state,
    output logic            wr_pend,
    output logic            wr_en,
    output logic [XLEN-1:0] rdata
);
    csr_sel_e sel;

    always_comb begin
        unique case (addr)
            ADDR_PEND: sel = SEL_PEND;
            ADDR_EN:   sel = SEL_EN;
            default:   sel = SEL_NONE;
        endcase
    end

    assign wr_pend = we && (sel == SEL_PEND);
    assign wr_en   = we && (sel == SEL_EN);

    always_comb begin
        case (sel)
            SEL_PEND: rdata = widen(state.pend);
            SEL_EN:   rdata = widen(state.en);
            default:  rdata = '0;
        endcase
    end

    // R4: upper read bits are always zero
    always_comb begin
        p_rdata_upper_r4: assert (rdata[XLEN-1:NSRC] == '0);
    end
    // R4: at most one register is written at a time
    always_comb begin
        p_one_write_r4: assert ($onehot0({wr_pend, wr_en}));
    end
endmodule

// File: rtl/swi_regs.sv
module swi_regs
    import swi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_pend,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wbits,
    output swi_state_t      state
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] en_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else if (wr_pend) begin
                pend_q[i] <= wbits[i];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i] <= 1'b0;
            end else if (wr_en) begin
                en_q[i] <= wbits[i];
            end
        end
    end

    assign state.pend = pend_q;
    assign state.en   = en_q;

    // R8: without a pending write the pending flags hold
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_pend |=> $stable(pend_q));
    // R8: without an enable write the enable flags hold
    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en_q));
    // R2: a pending write lands on the next edge
    p_pend_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_pend |=> pend_q == $past(wbits));
endmodule

// File: rtl/swi_prio.sv
module swi_prio
    import swi_pkg::*;
(
    input  swi_state_t      state,
    input  logic            glb_ie,
    output logic            irq_req,
    output logic [XLEN-1:0] irq_cause
);
    logic [NSRC-1:0] eligible;
    logic [NSRC:0]   found;
    int              winner [NSRC+1];

    assign eligible = state.pend & state.en & {NSRC{glb_ie}};

    // highest index wins: supervisor over user
    assign found[NSRC]  = 1'b0;
    assign winner[NSRC] = 0;
    for (genvar i = NSRC - 1; i >= 0; i--) begin : g_pick
        assign found[i]  = found[i+1] | eligible[i];
        assign winner[i] = found[i+1] ? winner[i+1] : i;
    end

    assign irq_req   = found[0];
    assign irq_cause = irq_req ? irq_cause_word(winner[0]) : '0;

    // R6: a request always carries an interrupt-class cause
    always_comb begin
        p_cause_class_r6: assert (!irq_req || irq_cause[XLEN-1]);
    end
    // R5: no request while the global enable is low
    always_comb begin
        p_global_gate_r5: assert (glb_ie || !irq_req);
    end
    // R6: supervisor eligibility forces the supervisor code
    always_comb begin
        p_supv_first_r6: assert (!eligible[SRC_SUPV] ||
            irq_cause == irq_cause_word(SRC_SUPV));
    end
endmodule

// File: rtl/swi_unit.sv
module swi_unit
    import swi_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    output logic [XLEN-1:0] csr_rdata,
    input  logic            glb_ie,
    input  logic            trap_ack,
    output logic            irq_req,
    output logic [XLEN-1:0] irq_cause
);
    swi_state_t state;
    logic       wr_pend;
    logic       wr_en;
    logic       unused_inputs;

    // acknowledge and high write bits intentionally do not reach state
    assign unused_inputs = &{1'b0, trap_ack, csr_wdata[XLEN-1:NSRC]};

    swi_csr_port u_port (
        .addr    (csr_addr),
        .we      (csr_we),
        .state   (state),
        .wr_pend (wr_pend),
        .wr_en   (wr_en),
        .rdata   (csr_rdata)
    );

    swi_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_pend (wr_pend),
        .wr_en   (wr_en),
        .wbits   (csr_wdata[NSRC-1:0]),
        .state   (state)
    );

    swi_prio u_prio (
        .state     (state),
        .glb_ie    (glb_ie),
        .irq_req   (irq_req),
        .irq_cause (irq_cause)
    );

    // R7: acknowledge alone never clears a pending flag
    p_ack_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_ack && !csr_we) |=> $stable(state.pend));
    // R1: the cycle after reset everything is clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state.pend == '0 && state.en == '0));
endmodule

// File: tb/swi_unit_tb.sv
`timescale 1ns/1ps
module swi_unit_tb;
    localparam logic [11:0] A_PEND = 12'h7C4;
    localparam logic [11:0] A_EN   = 12'h7C0;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata;
    logic        csr_we;
    logic [31:0] csr_rdata;
    logic        glb_ie;
    logic        trap_ack;
    logic        irq_req;
    logic [31:0] irq_cause;

    int checks = 0;
    int errors = 0;
    bit m_pend [2];
    bit m_en   [2];

    always #2.5 clk = ~clk;

    swi_unit u_dut (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata), .glb_ie(glb_ie),
        .trap_ack(trap_ack), .irq_req(irq_req), .irq_cause(irq_cause)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] reg_val(input bit b1, input bit b0);
        return {30'd0, b1, b0};
    endfunction

    // compares every output against the reference, then clocks once
    task automatic step(input logic [11:0] a, input logic [31:0] d,
                        input logic we, input logic gie, input logic ack,
                        input string req);
        logic [31:0] exp_rd;
        bit          u_ok;
        bit          s_ok;
        logic [31:0] exp_cause;
        csr_addr = a; csr_wdata = d; csr_we = we; glb_ie = gie; trap_ack = ack;
        #1;
        if (a == A_PEND)    exp_rd = reg_val(m_pend[1], m_pend[0]);
        else if (a == A_EN) exp_rd = reg_val(m_en[1], m_en[0]);
        else                exp_rd = 32'd0;
        s_ok = gie && m_pend[1] && m_en[1];
        u_ok = gie && m_pend[0] && m_en[0];
        exp_cause = s_ok ? 32'h8000_0001 : (u_ok ? 32'h8000_0000 : 32'd0);
        check({req, "/R4"}, "csr_rdata", csr_rdata, exp_rd);
        check({req, "/R5"}, "irq_req", {31'd0, irq_req}, {31'd0, s_ok | u_ok});
        check({req, "/R6"}, "irq_cause", irq_cause, exp_cause);
        @(posedge clk);
        if (we && a == A_PEND) begin m_pend[0] = d[0]; m_pend[1] = d[1]; end
        if (we && a == A_EN)   begin m_en[0] = d[0];   m_en[1] = d[1];   end
        @(negedge clk);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; csr_addr = '0; csr_wdata = '0; csr_we = 1'b0;
        glb_ie = 1'b0; trap_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        step(A_PEND, 0, 0, 1, 0, "R1");
        step(A_EN,   0, 0, 1, 0, "R1");
        // R2: both pending, no enables, no request
        step(A_PEND, 32'h3, 1, 1, 0, "R2");
        step(A_PEND, 0, 0, 1, 0, "R2");
        // R3: user enable only
        step(A_EN, 32'h1, 1, 1, 0, "R3");
        step(A_EN, 0, 0, 1, 0, "R3");
        // R6: supervisor enable only, then both
        step(A_EN, 32'h2, 1, 1, 0, "R6");
        step(A_EN, 32'h3, 1, 1, 0, "R6");
        step(A_PEND, 0, 0, 1, 0, "R6");
        // R5: global enable off masks everything
        step(A_PEND, 0, 0, 0, 0, "R5");
        step(A_EN, 0, 0, 0, 0, "R5");
        // R7: acknowledge repeatedly, request persists
        for (int i = 0; i < 4; i++) step(A_PEND, 0, 0, 1, 1, "R7");
        // R2: clear supervisor only, user remains
        step(A_PEND, 32'h1, 1, 1, 1, "R2");
        step(A_PEND, 0, 0, 1, 0, "R2");
        // R4: upper bits only, flags cleared and upper read zero
        step(A_PEND, 32'hFFFF_FFFC, 1, 1, 0, "R4");
        step(A_PEND, 0, 0, 1, 0, "R4");
        step(A_PEND, 32'hFFFF_FFFF, 1, 1, 0, "R4");
        // R4: unmapped address write has no effect
        step(12'h7C8, 32'h0, 1, 1, 0, "R4");
        step(12'h300, 32'h0, 1, 1, 0, "R4");
        step(A_PEND, 0, 0, 1, 0, "R4");
        step(A_EN, 0, 0, 1, 0, "R4");
        // R8: strobe low, write data ignored
        step(A_PEND, 32'h0, 0, 1, 0, "R8");
        step(A_EN, 32'h0, 0, 1, 0, "R8");
        step(A_PEND, 0, 0, 1, 0, "R8");
        // R3: disable user, supervisor still wins alone
        step(A_EN, 32'h2, 1, 1, 0, "R3");
        step(A_PEND, 32'h1, 1, 1, 0, "R3");
        step(A_EN, 32'h1, 1, 1, 0, "R3");
        step(A_PEND, 0, 0, 1, 0, "R3");
        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend[0] = 0; m_pend[1] = 0; m_en[0] = 0; m_en[1] = 0;
        step(A_PEND, 0, 0, 1, 0, "R1");
        step(A_EN, 0, 0, 1, 0, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule